// File: doc/BRIEF.md
# Time-indexed rolling capture buffer

This block keeps a running history of sampled data in a circular store. Every sample is written to the next address and the block remembers the shared-timescale time of the newest write. Because samples arrive at a fixed period of `2**PERIOD_LG2` time ticks, every stored location maps to a known time. When a trigger arrives with the time of some earlier event, the block works out the address of the sample for that time. It keeps capturing for a set number of post-trigger samples and then freezes. It then streams out a window that starts a set number of samples before that address.

The trigger is a time value sent from elsewhere, so it always refers to the past. The store must be deep enough to cover the worst-case trigger delay plus the window. A trigger that asks for samples the store no longer holds, or never held, is rejected with a one-cycle error pulse and gives no readout. Both sides move data with valid/ready handshakes. A sample transfers on a cycle where `s_valid` and `s_ready` are both high. `s_ready` is low in the cycle a trigger is presented, once the post-trigger count is reached, and for the whole readout. A source that cannot stall loses samples while `s_ready` is low. For that reason the history is discarded when readout ends. On the output, a beat transfers on `m_valid && m_ready`. While `m_ready` is low, the beat stays on the pins unchanged.

Top module: `timed_capture_buffer`

## Requirements
- R1: Out of reset, `s_ready` is 1, `m_valid` is 0, `trig_err` is 0, and no sample history is held.
- R2: While capturing, each accepted sample goes to the next address, wrapping modulo `2**ADDR_W`, and the `now_time` value present at its transfer becomes the newest time.
- R3: The target sample index is the newest index minus floor((newest time − `trig_time`) / 2**PERIOD_LG2). A trigger time that falls between two samples therefore resolves to the first sample at or after it.
- R4: A trigger is rejected when age + pre + post ≥ 2**ADDR_W, where age is the sample distance of R3. On rejection, `trig_err` is high for exactly the cycle after the trigger, no readout follows, and capture continues.
- R5: A trigger is also rejected when age + pre ≥ the number of samples accepted since the history was last cleared. This covers an empty history and a trigger time later than the newest sample, whose age wraps to a huge value.
- R6: `s_ready` is low in any cycle where `trig_stb` is high. After an accepted trigger, exactly `cfg_post` further samples (sampled at the trigger) are accepted, and `s_ready` then stays low until readout ends.
- R7: Readout delivers pre + post samples, oldest first: target−pre up to target+post−1. When `cfg_post` is 0, the window ends just before the target. The window may cross the wrap point of the store.
- R8: `m_first` is high only on the first beat of a window and `m_last` only on its final beat. `m_valid` falls after the final transfer.
- R9: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data`, `m_first` and `m_last` hold their values, and no beat is lost or repeated.
- R10: A trigger presented during the post-trigger phase or during readout is ignored: no error pulse and no change to the window being streamed.
- R11: When readout completes, `s_ready` returns high and the sample history is cleared. A trigger needing samples from before the clear is then rejected under R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pre | input | ADDR_W | Samples to stream before the target, taken at trigger acceptance |
| cfg_post | input | ADDR_W | Samples from the target onward, taken at trigger acceptance |
| s_valid | input | 1 | Sample offered |
| s_ready | output | 1 | Block accepts a sample |
| s_data | input | DATA_W | Sample value |
| now_time | input | TIME_W | Shared-timescale time of the offered sample |
| trig_stb | input | 1 | Trigger strobe, one cycle |
| trig_time | input | TIME_W | Time of the triggering condition |
| trig_err | output | 1 | One-cycle pulse: trigger rejected |
| m_valid | output | 1 | Readout beat present |
| m_ready | input | 1 | Consumer takes the beat |
| m_data | output | DATA_W | Readout sample |
| m_first | output | 1 | Beat is the oldest sample of the window |
| m_last | output | 1 | Beat is the final sample of the window |

## Verification
The assertions check, on every cycle, the handshake rules that can be judged locally. They check that input is refused during readout and that a stalled beat is held. They also check that an error pulse only follows a trigger strobe and never appears during readout, and that the first and last markers open and close a window. What only the bench scenarios can show is whether the time-to-address arithmetic picks the right sample. This includes fractional trigger times, windows that straddle the wrap point, the exact reject boundaries on buffer span and on history length, the post-trigger count, and the clearing of history after a readout.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  typedef enum logic [1:0] {
    ST_CAPTURE = 2'd0,
    ST_POST    = 2'd1,
    ST_READ    = 2'd2
  } tcb_state_e;
endpackage

// File: rtl/tcb_store.sv
// Circular sample store: one synchronous write port, one combinational read port.
module tcb_store #(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/tcb_locate.sv
// Resolves a trigger time into a window start address and decides whether
// the requested window is still held in the store.
module tcb_locate #(
  parameter int ADDR_W     = 6,
  parameter int TIME_W     = 32,
  parameter int PERIOD_LG2 = 2
) (
  input  logic [TIME_W-1:0] newest_time,
  input  logic [TIME_W-1:0] trig_time,
  input  logic [ADDR_W-1:0] newest_addr,
  input  logic [ADDR_W:0]   fill,
  input  logic [ADDR_W-1:0] pre,
  input  logic [ADDR_W-1:0] post,
  output logic [ADDR_W-1:0] start_addr,
  output logic              reject
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SW    = TIME_W + 2;

  logic [TIME_W-1:0] delta;
  logic [TIME_W-1:0] age;
  logic [SW-1:0]     span_need;
  logic [SW-1:0]     hist_need;
  logic [ADDR_W-1:0] target;

  always_comb begin
    delta     = newest_time - trig_time;
    age       = delta >> PERIOD_LG2;
    hist_need = {2'b00, age} + SW'(pre);
    span_need = hist_need + SW'(post);
    reject    = (span_need >= SW'(DEPTH)) || (hist_need >= SW'(fill));
    target    = newest_addr - age[ADDR_W-1:0];
    start_addr = target - pre;
  end
endmodule

// File: rtl/tcb_ctrl.sv
// Capture / post-trigger / readout sequencer.
module tcb_ctrl
  import tcb_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [TIME_W-1:0] now_time,
  input  logic              trig_stb,
  input  logic [ADDR_W-1:0] cfg_pre,
  input  logic [ADDR_W-1:0] cfg_post,
  input  logic              loc_reject,
  input  logic [ADDR_W-1:0] loc_start,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [TIME_W-1:0] newest_time,
  output logic [ADDR_W-1:0] newest_addr,
  output logic [ADDR_W:0]   fill,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              m_first,
  output logic              m_last,
  output logic              trig_err
);
  localparam int DEPTH = 1 << ADDR_W;

  tcb_state_e        st;
  logic [ADDR_W-1:0] wr_ptr;
  logic [ADDR_W-1:0] post_left;
  logic [ADDR_W-1:0] rd_ptr;
  logic [ADDR_W:0]   rd_left;
  logic              first_q;
  logic              s_fire;

  always_comb begin
    s_ready = !trig_stb &&
              ((st == ST_CAPTURE) || ((st == ST_POST) && (post_left != '0)));
    s_fire      = s_valid && s_ready;
    wr_en       = s_fire;
    wr_addr     = wr_ptr;
    newest_addr = wr_ptr - 1'b1;
    rd_addr     = rd_ptr;
    m_valid     = (st == ST_READ);
    m_first     = first_q;
    m_last      = (st == ST_READ) && (rd_left == (ADDR_W+1)'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_CAPTURE;
      wr_ptr      <= '0;
      fill        <= '0;
      newest_time <= '0;
      post_left   <= '0;
      rd_ptr      <= '0;
      rd_left     <= '0;
      first_q     <= 1'b0;
      trig_err    <= 1'b0;
    end else begin
      trig_err <= 1'b0;
      if (s_fire) begin
        wr_ptr      <= wr_ptr + 1'b1;
        newest_time <= now_time;
        if (fill != (ADDR_W+1)'(DEPTH)) fill <= fill + 1'b1;
      end
      unique case (st)
        ST_CAPTURE: begin
          if (trig_stb) begin
            if (loc_reject) begin
              trig_err <= 1'b1;
            end else begin
              st        <= ST_POST;
              post_left <= cfg_post;
              rd_ptr    <= loc_start;
              rd_left   <= {1'b0, cfg_pre} + {1'b0, cfg_post};
            end
          end
        end
        ST_POST: begin
          if (post_left == '0) begin
            st      <= ST_READ;
            first_q <= 1'b1;
          end else if (s_fire) begin
            post_left <= post_left - 1'b1;
          end
        end
        ST_READ: begin
          if (m_ready) begin
            rd_ptr  <= rd_ptr + 1'b1;
            rd_left <= rd_left - 1'b1;
            first_q <= 1'b0;
            if (rd_left == (ADDR_W+1)'(1)) begin
              st   <= ST_CAPTURE;
              fill <= '0;
            end
          end
        end
        default: st <= ST_CAPTURE;
      endcase
    end
  end
endmodule

// File: rtl/timed_capture_buffer.sv
module timed_capture_buffer #(
  parameter int DATA_W     = 12,
  parameter int ADDR_W     = 6,
  parameter int TIME_W     = 32,
  parameter int PERIOD_LG2 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_pre,
  input  logic [ADDR_W-1:0] cfg_post,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic [TIME_W-1:0] now_time,
  input  logic              trig_stb,
  input  logic [TIME_W-1:0] trig_time,
  output logic              trig_err,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_first,
  output logic              m_last
);
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic [TIME_W-1:0] newest_time;
  logic [ADDR_W-1:0] newest_addr;
  logic [ADDR_W:0]   fill;
  logic [ADDR_W-1:0] loc_start;
  logic              loc_reject;

  tcb_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (s_data),
    .rd_addr (rd_addr),
    .rd_data (m_data)
  );

  tcb_locate #(.ADDR_W(ADDR_W), .TIME_W(TIME_W), .PERIOD_LG2(PERIOD_LG2)) u_locate (
    .newest_time (newest_time),
    .trig_time   (trig_time),
    .newest_addr (newest_addr),
    .fill        (fill),
    .pre         (cfg_pre),
    .post        (cfg_post),
    .start_addr  (loc_start),
    .reject      (loc_reject)
  );

  tcb_ctrl #(.ADDR_W(ADDR_W), .TIME_W(TIME_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .s_valid     (s_valid),
    .s_ready     (s_ready),
    .now_time    (now_time),
    .trig_stb    (trig_stb),
    .cfg_pre     (cfg_pre),
    .cfg_post    (cfg_post),
    .loc_reject  (loc_reject),
    .loc_start   (loc_start),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .newest_time (newest_time),
    .newest_addr (newest_addr),
    .fill        (fill),
    .rd_addr     (rd_addr),
    .m_valid     (m_valid),
    .m_ready     (m_ready),
    .m_first     (m_first),
    .m_last      (m_last),
    .trig_err    (trig_err)
  );
endmodule

// File: rtl/tcb_checker.sv
module tcb_checker #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_ready,
  input logic              trig_stb,
  input logic              trig_err,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data,
  input logic              m_first,
  input logic              m_last
);
  AST_NO_INTAKE_IN_READOUT: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !s_ready) else $error("AST_NO_INTAKE_IN_READOUT"); // R6

  AST_READY_LOW_ON_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    trig_stb |-> !s_ready) else $error("AST_READY_LOW_ON_TRIG"); // R6

  AST_STALL_HOLDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_first) && $stable(m_last)))
    else $error("AST_STALL_HOLDS_BEAT"); // R9

  AST_ERR_FOLLOWS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    trig_err |-> $past(trig_stb)) else $error("AST_ERR_FOLLOWS_TRIG"); // R4

  AST_ERR_NOT_IN_READOUT: assert property (@(posedge clk) disable iff (!rst_n)
    trig_err |-> !m_valid) else $error("AST_ERR_NOT_IN_READOUT"); // R4

  AST_BUSY_TRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && trig_stb) |=> !trig_err) else $error("AST_BUSY_TRIG_IGNORED"); // R10

  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && m_last) |=> !m_valid) else $error("AST_LAST_CLOSES"); // R8

  AST_FIRST_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && !m_last) |=> !m_first) else $error("AST_FIRST_ONCE"); // R8
endmodule

bind timed_capture_buffer tcb_checker #(.DATA_W(DATA_W)) u_tcb_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .s_ready  (s_ready),
  .trig_stb (trig_stb),
  .trig_err (trig_err),
  .m_valid  (m_valid),
  .m_ready  (m_ready),
  .m_data   (m_data),
  .m_first  (m_first),
  .m_last   (m_last)
);

// File: tb/test_timed_capture_buffer.sv
`timescale 1ns/1ps
module test_timed_capture_buffer;
  localparam int DATA_W = 12;
  localparam int ADDR_W = 6;
  localparam int TIME_W = 32;
  localparam int TICKS  = 4;   // 2**PERIOD_LG2

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] cfg_pre = '0;
  logic [ADDR_W-1:0] cfg_post = '0;
  logic              s_valid = 1'b0;
  logic              s_ready;
  logic [DATA_W-1:0] s_data = '0;
  logic [TIME_W-1:0] now_time = '0;
  logic              trig_stb = 1'b0;
  logic [TIME_W-1:0] trig_time = '0;
  logic              trig_err;
  logic              m_valid;
  logic              m_ready = 1'b0;
  logic [DATA_W-1:0] m_data;
  logic              m_first;
  logic              m_last;

  int checks = 0;
  int fails  = 0;
  int g      = 0;   // index of next sample to be offered
  bit done   = 1'b0;

  always #2 clk = ~clk;

  timed_capture_buffer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TIME_W(TIME_W), .PERIOD_LG2(2))
    i_timed_capture_buffer (.*);

  function automatic logic [DATA_W-1:0] fval(int idx);
    return DATA_W'(idx * 37 + 5);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = fval(g); now_time = TIME_W'(g * TICKS);
      #1;
      if (s_ready) begin @(posedge clk); g++; end
      else chk(1'b0, "R2 sample refused while capturing", 0, 1);
    end
    @(negedge clk); s_valid = 1'b0;
  endtask

  task automatic send_until_stall(output int acc);
    acc = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = fval(g); now_time = TIME_W'(g * TICKS);
      #1;
      if (!s_ready) break;
      @(posedge clk); g++; acc++;
    end
    s_valid = 1'b0;
  endtask

  task automatic trigger(int t, int pre, int post, output bit err);
    @(negedge clk);
    cfg_pre = ADDR_W'(pre); cfg_post = ADDR_W'(post);
    trig_stb = 1'b1; trig_time = TIME_W'(t);
    @(negedge clk);
    trig_stb = 1'b0;
    err = trig_err;
  endtask

  task automatic read_window(int n, bit stall, int first_idx);
    int got = 0;
    for (int i = 0; i < 400 && got < n; i++) begin
      @(negedge clk);
      m_ready = stall ? i[0] : 1'b1;
      #1;
      if (m_valid && m_ready) begin
        chk(m_data == fval(first_idx + got), "R7 window data", int'(m_data), int'(fval(first_idx + got)));
        chk(m_first == (got == 0), "R8 first marker", int'(m_first), int'(got == 0));
        chk(m_last == (got == n - 1), "R8 last marker", int'(m_last), int'(got == n - 1));
        got++;
      end
      @(posedge clk);
    end
    @(negedge clk); m_ready = 1'b0; #1;
    chk(got == n, "R7 window length", got, n);
    chk(!m_valid, "R8 valid drops after last", int'(m_valid), 0);
    chk(s_ready, "R11 capture resumes", int'(s_ready), 1);
    g += 10;   // time advances while input was refused
  endtask

  task automatic t_reset;
    chk(s_ready, "R1 s_ready after reset", int'(s_ready), 1);
    chk(!m_valid, "R1 m_valid after reset", int'(m_valid), 0);
    chk(!trig_err, "R1 trig_err after reset", int'(trig_err), 0);
  endtask

  task automatic t_basic;  // R2 R3 R6 R7
    bit err; int acc;
    send(40);
    trigger(30 * TICKS, 4, 3, err);
    chk(!err, "R3 basic trigger accepted", int'(err), 0);
    send_until_stall(acc);
    chk(acc == 3, "R6 post-trigger count", acc, 3);
    read_window(7, 1'b0, 26);
  endtask

  task automatic t_wrap_fraction;  // R3 fractional, R7 wrap, R9 stall
    bit err; int acc; int base;
    base = g;
    send(70);
    trigger((base + 26) * TICKS + 2, 10, 5, err);   // resolves to sample base+27
    chk(!err, "R3 fractional trigger accepted", int'(err), 0);
    send_until_stall(acc);
    chk(acc == 5, "R6 post-trigger count", acc, 5);
    read_window(15, 1'b1, base + 17);
  endtask

  task automatic t_busy_trigger;  // R10
    bit err; int acc; int base;
    base = g;
    send(20);
    trigger((base + 15) * TICKS, 2, 2, err);
    chk(!err, "R10 setup trigger accepted", int'(err), 0);
    send_until_stall(acc);
    for (int i = 0; i < 10 && !m_valid; i++) @(negedge clk);
    trigger((base + 18) * TICKS, 1, 1, err);
    chk(!err, "R10 trigger during readout ignored", int'(err), 0);
    #1;
    chk(m_valid && m_first, "R10 window unchanged", int'(m_first), 1);
    chk(m_data == fval(base + 13), "R10 window data unchanged", int'(m_data), int'(fval(base + 13)));
    read_window(4, 1'b0, base + 13);
  endtask

  task automatic t_too_old;  // R4
    bit err; int acc; int last;
    send(70);
    last = g - 1;
    trigger((last - 60) * TICKS, 4, 3, err);
    chk(err, "R4 span exceeded rejected", int'(err), 1);
    @(negedge clk); #1;
    chk(!trig_err, "R4 error is one cycle", int'(trig_err), 0);
    chk(!m_valid && s_ready, "R4 no readout, capture continues", int'(m_valid), 0);
    send(1);
    last = g - 1;
    trigger((last - 56) * TICKS, 4, 3, err);   // 56+4+3 = 63: largest accepted
    chk(!err, "R4 boundary accepted", int'(err), 0);
    send_until_stall(acc);
    read_window(7, 1'b0, last - 60);
  endtask

  task automatic t_history;  // R5 R11, post = 0
    bit err; int acc; int last;
    send(5);
    last = g - 1;
    trigger(last * TICKS, 8, 1, err);
    chk(err, "R11 history cleared after readout", int'(err), 1);
    trigger((last + 3) * TICKS, 0, 1, err);
    chk(err, "R5 future trigger rejected", int'(err), 1);
    trigger(last * TICKS, 4, 0, err);
    chk(!err, "R5 history just sufficient", int'(err), 0);
    send_until_stall(acc);
    chk(acc == 0, "R6 zero post count", acc, 0);
    read_window(4, 1'b0, last - 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_basic();
    t_wrap_fraction();
    t_busy_trigger();
    t_too_old();
    t_history();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
    if (!done) chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule